// File: doc/BRIEF.md
# Predicated Vector Operation Splitter

This block accepts one vector operation at a time. An operation is a base register index, an element count and a per-element enable mask. Over the following cycles the block turns it into groups of scalar element operations for an execution unit that takes up to `ISSUE_W` operations per cycle. Disabled elements and elements past the element count are never issued. The enabled elements are packed into the lowest issue slots, so no slot carries a disabled lane. After every accepted group, the held operation is rewritten with the issued elements removed. When nothing is left, a one-cycle `done` pulse marks the end of the operation.

A small state machine sequences the work. `ST_IDLE` waits for an operation, with `in_ready` high. The transition *accept-work* goes to `ST_ISSUE` when at least one element is enabled. The transition *accept-empty* goes straight to `ST_FINISH` when none is. `ST_ISSUE` presents one group per cycle. On *group-taken* it stays in `ST_ISSUE` while elements remain. On *last-group* it moves to `ST_FINISH`. `ST_FINISH` raises `done` for one cycle and then takes *finish-return* back to `ST_IDLE`.

The issue width, the maximum vector length and the register index width are build-time parameters. The operation format seen on the input does not depend on them.

Top module: `vsplit_top`

## Requirements
- R1: After reset, `in_ready` is 1 and both `out_valid` and `done` are 0.
- R2: An operation is accepted only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is high only in `ST_IDLE`, so input presented while an operation is in progress is ignored and never reaches the output.
- R3: Element positions at or above `in_len` are never issued. An `in_len` of `VL_MAX` or more enables every mask position.
- R4: Each group carries the lowest remaining enabled element positions in ascending order, with slot 0 holding the lowest.
- R5: The index in slot k, at bits `[k*REG_W +: REG_W]` of `out_idx`, equals the base plus that element's position, modulo 2^`REG_W`.
- R6: While `out_valid` is high, `out_slot_valid` is a contiguous run of ones starting at bit 0, and its width equals the count of elements in the group. A final group may be partial.
- R7: While `out_valid` is high and `out_ready` is low, the group contents stay unchanged. The held remainder changes only on a completed output handshake.
- R8: `done` is high for exactly one cycle: the cycle after the final group's handshake. `out_valid` and `in_ready` are low in that cycle, and `in_ready` returns the cycle after.
- R9: An operation whose enabled set is empty (zero mask, zero length, or mask bits only at positions at or above the length) issues nothing and raises `done` in the cycle after acceptance.
- R10: An operation with P enabled elements takes exactly ceil(P / `ISSUE_W`) output handshakes. With width 4, six enabled elements go out as four, then two.
- R11: `out_valid` rises in the cycle after an operation with at least one enabled element is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Vector operation offered |
| in_ready | output | 1 | Block can accept an operation |
| in_base | input | REG_W | Base register index |
| in_len | input | LEN_W | Element count (values of `VL_MAX` or more mean all) |
| in_mask | input | VL_MAX | Per-element enable, bit i for element i |
| out_valid | output | 1 | A group of scalar operations is presented |
| out_ready | input | 1 | Execution unit takes the group |
| out_slot_valid | output | ISSUE_W | Per-slot valid, packed from slot 0 |
| out_idx | output | ISSUE_W*REG_W | Register index per slot, slot k at `[k*REG_W +: REG_W]` |
| done | output | 1 | One-cycle pulse when an operation is complete |

## Verification
The assertions assume `rst_n` is held low for at least one clock edge before any traffic. They also assume that `out_ready` may fall at any time while a group is shown, since the hold rule is meant to cover exactly that case. They do not assume that `in_valid` stays low while the block is busy. The stimulus drives every input on the falling edge and holds `in_valid` for one cycle per operation. It deliberately raises `in_valid` with a different operation during an active one, and it stalls `out_ready` across several cycles mid-operation, so that the ignore and hold properties see real pressure.

// File: rtl/vsplit_pkg.sv
package vsplit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } vs_state_e;

endpackage

// File: rtl/vsplit_lenmask.sv
module vsplit_lenmask #(
    parameter int VL_MAX = 8,
    parameter int LEN_W  = $clog2(VL_MAX + 1)
) (
    input  logic [LEN_W-1:0]  len,
    output logic [VL_MAX-1:0] mask
);

    // Element i is inside the vector when the count exceeds i.
    for (genvar i = 0; i < VL_MAX; i++) begin : g_pos
        assign mask[i] = (len > LEN_W'(i));
    end

endmodule

// File: rtl/vsplit_pick.sv
module vsplit_pick #(
    parameter int VL_MAX  = 8,
    parameter int ISSUE_W = 4,
    parameter int POS_W   = $clog2(VL_MAX)
) (
    input  logic [VL_MAX-1:0]        avail,
    output logic [ISSUE_W-1:0]       slot_valid,
    output logic [ISSUE_W*POS_W-1:0] slot_pos,
    output logic [VL_MAX-1:0]        taken
);

    // Stage k removes the lowest set bit left after stages 0..k-1.
    logic [VL_MAX-1:0] chain [ISSUE_W+1];

    assign chain[0] = avail;

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
        logic [VL_MAX-1:0] lowest;
        logic [POS_W-1:0]  pos;

        assign lowest = chain[k] & (~chain[k] + VL_MAX'(1));

        always_comb begin
            pos = '0;
            for (int i = 0; i < VL_MAX; i++) begin
                if (lowest[i]) begin
                    pos = pos | POS_W'(i);
                end
            end
        end

        assign slot_valid[k]                = |chain[k];
        assign slot_pos[k*POS_W +: POS_W]   = pos;
        assign chain[k+1]                   = chain[k] & ~lowest;
    end

    assign taken = chain[0] & ~chain[ISSUE_W];

endmodule

// File: rtl/vsplit_top.sv
module vsplit_top
    import vsplit_pkg::*;
#(
    parameter int VL_MAX  = 8,
    parameter int ISSUE_W = 4,
    parameter int REG_W   = 7,
    localparam int LEN_W  = $clog2(VL_MAX + 1),
    localparam int POS_W  = $clog2(VL_MAX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [REG_W-1:0]         in_base,
    input  logic [LEN_W-1:0]         in_len,
    input  logic [VL_MAX-1:0]        in_mask,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [ISSUE_W-1:0]       out_slot_valid,
    output logic [ISSUE_W*REG_W-1:0] out_idx,
    output logic                     done
);

    vs_state_e          state_q, state_d;
    logic [REG_W-1:0]   base_q;
    logic [VL_MAX-1:0]  pend_q, pend_d;
    logic [REG_W-1:0]   base_d;

    logic [VL_MAX-1:0]        len_mask;
    logic [VL_MAX-1:0]        eff_mask;
    logic [ISSUE_W-1:0]       pick_valid;
    logic [ISSUE_W*POS_W-1:0] pick_pos;
    logic [VL_MAX-1:0]        pick_taken;
    logic [VL_MAX-1:0]        left_after;
    logic [ISSUE_W*REG_W-1:0] slot_idx;

    vsplit_lenmask #(
        .VL_MAX (VL_MAX),
        .LEN_W  (LEN_W)
    ) u_lenmask (
        .len  (in_len),
        .mask (len_mask)
    );

    assign eff_mask = in_mask & len_mask;

    vsplit_pick #(
        .VL_MAX  (VL_MAX),
        .ISSUE_W (ISSUE_W),
        .POS_W   (POS_W)
    ) u_pick (
        .avail      (pend_q),
        .slot_valid (pick_valid),
        .slot_pos   (pick_pos),
        .taken      (pick_taken)
    );

    assign left_after = pend_q & ~pick_taken;

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_idx
        assign slot_idx[k*REG_W +: REG_W] =
            base_q + REG_W'(pick_pos[k*POS_W +: POS_W]);
    end

    // Next-state and remainder logic.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        base_d  = base_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    base_d  = in_base;
                    pend_d  = eff_mask;
                    state_d = (eff_mask == '0) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (out_ready) begin
                    pend_d = left_after;
                    if (left_after == '0) begin
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Held operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            base_q <= '0;
        end else begin
            pend_q <= pend_d;
            base_q <= base_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        in_ready       = 1'b0;
        out_valid      = 1'b0;
        done           = 1'b0;
        out_slot_valid = '0;
        out_idx        = '0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_ISSUE: begin
                out_valid      = 1'b1;
                out_slot_valid = pick_valid;
                out_idx        = slot_idx;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vsplit_chk.sv
module vsplit_chk #(
    parameter int ISSUE_W = 4,
    parameter int REG_W   = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [ISSUE_W-1:0]       out_slot_valid,
    input logic [ISSUE_W*REG_W-1:0] out_idx,
    input logic                     done
);

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid && (out_slot_valid == '0))); // R2

    AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot_valid[0] &&
                       ((out_slot_valid & (out_slot_valid + 1'b1)) == '0))); // R6

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_slot_valid) && $stable(out_idx))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !in_ready)); // R8

    AST_DONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready); // R8

endmodule

bind vsplit_top vsplit_chk #(
    .ISSUE_W (ISSUE_W),
    .REG_W   (REG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_slot_valid (out_slot_valid),
    .out_idx        (out_idx),
    .done           (done)
);

// File: tb/vsplit_top_bench.sv
module vsplit_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int VL  = 8;
    localparam int W   = 4;
    localparam int RW  = 7;
    localparam int LW  = 4;
    localparam int NVEC = 8;

    // {base[6:0], len[3:0], mask[7:0]}
    localparam logic [18:0] VECS [NVEC] = '{
        {7'd10,  4'd8,  8'hB7},  // six active: 4 then 2 (R10)
        {7'd0,   4'd8,  8'hFF},  // two full groups
        {7'd3,   4'd5,  8'hFF},  // length cuts mask (R3)
        {7'd126, 4'd8,  8'h81},  // index wraps (R5)
        {7'd20,  4'd0,  8'hFF},  // zero length (R9)
        {7'd20,  4'd8,  8'h00},  // zero mask (R9)
        {7'd50,  4'd15, 8'hC0},  // length above max (R3)
        {7'd1,   4'd3,  8'hF8}   // mask only past length (R9)
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [RW-1:0]     in_base = '0;
    logic [LW-1:0]     in_len = '0;
    logic [VL-1:0]     in_mask = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [W-1:0]      out_slot_valid;
    logic [W*RW-1:0]   out_idx;
    logic              done;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsplit_top #(
        .VL_MAX  (VL),
        .ISSUE_W (W),
        .REG_W   (RW)
    ) u_vsplit_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_base        (in_base),
        .in_len         (in_len),
        .in_mask        (in_mask),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_slot_valid (out_slot_valid),
        .out_idx        (out_idx),
        .done           (done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] slot_of(input int k);
        return 32'(out_idx[k*RW +: RW]);
    endfunction

    // Offer one operation and follow it to done with out_ready held high.
    task automatic run_op(input logic [RW-1:0] b, input logic [LW-1:0] l, input logic [VL-1:0] m);
        int pos[VL];
        int n = 0;
        for (int i = 0; i < VL; i++) begin
            if (m[i] && (i < int'(l))) begin
                pos[n] = i;
                n++;
            end
        end
        check("R2 ready before offer", 32'(in_ready), 1);
        in_valid = 1'b1;
        in_base  = b;
        in_len   = l;
        in_mask  = m;
        @(negedge clk);
        in_valid = 1'b0;
        if (n == 0) begin
            check("R9 no issue on empty op", 32'(out_valid), 0);
            check("R9 done after accept", 32'(done), 1);
        end else begin
            for (int g = 0; g * W < n; g++) begin
                int cnt = (n - g * W) < W ? (n - g * W) : W;
                check("R11/R10 group valid", 32'(out_valid), 1);
                check("R6 slot valid", 32'(out_slot_valid), 32'((1 << cnt) - 1));
                for (int s = 0; s < cnt; s++) begin
                    check("R4/R5 slot index", slot_of(s), 32'((int'(b) + pos[g*W+s]) & ((1 << RW) - 1)));
                end
                @(negedge clk);
            end
            check("R8/R10 done after last group", 32'(done), 1);
            check("R8 no output while done", 32'(out_valid), 0);
        end
        check("R8 ready low while done", 32'(in_ready), 0);
        @(negedge clk);
        check("R8 done one cycle", 32'(done), 0);
        check("R8 ready returns", 32'(in_ready), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in_ready in reset", 32'(in_ready), 1);
        check("R1 out_valid in reset", 32'(out_valid), 0);
        check("R1 done in reset", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", 32'(in_ready), 1);
        check("R1 out_valid after reset", 32'(out_valid), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_op(VECS[v][18:12], VECS[v][11:8], VECS[v][7:0]);
        end

        // R7: stall mid-operation, group holds and remainder is kept.
        in_valid = 1'b1; in_base = 7'd10; in_len = 4'd8; in_mask = 8'hB7;
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check("R7 held valid", 32'(out_valid), 1);
            check("R7 held slots", 32'(out_slot_valid), 32'h0F);
            check("R7 held slot0", slot_of(0), 10);
            check("R7 held slot3", slot_of(3), 14);
            @(negedge clk);
        end
        out_ready = 1'b1;
        check("R7 first group after stall", slot_of(2), 12);
        @(negedge clk);
        check("R7 remainder slots", 32'(out_slot_valid), 32'h03);
        check("R7 remainder slot0", slot_of(0), 15);
        check("R7 remainder slot1", slot_of(1), 17);
        @(negedge clk);
        check("R8 done after stall op", 32'(done), 1);
        @(negedge clk);

        // R2: input offered while busy is ignored.
        in_valid = 1'b1; in_base = 7'd0; in_len = 4'd8; in_mask = 8'h03;
        out_ready = 1'b0;
        @(negedge clk);
        in_base = 7'd40; in_mask = 8'hFF;
        check("R2 busy not ready", 32'(in_ready), 0);
        @(negedge clk);
        check("R2 slots unchanged", 32'(out_slot_valid), 32'h03);
        check("R2 slot0 unchanged", slot_of(0), 0);
        check("R2 slot1 unchanged", slot_of(1), 1);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check("R2 done for first op only", 32'(done), 1);
        @(negedge clk);
        check("R2 idle after", 32'(in_ready), 1);
        @(negedge clk);
        check("R2 no foreign issue", 32'(out_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule